// File: doc/BRIEF.md
# ADC Trigger and Result-Status Controller

This block is the digital front end of a successive-approximation converter. Software writes a 3-bit start-mode field and an edge-polarity bit. From them the block decides when to send the converter a one-cycle start pulse: never, at once on the write, or on a chosen edge of one of six external trigger lines. The trigger lines are synchronized inside the block. A burst-mode input overrides the mode field and keeps the converter running back to back.

When the converter signals completion, the block captures the 10-bit result and the channel code into a 32-bit data word. That word carries a completion flag and an overrun flag. Reading the word clears both flags. Writing the control fields clears the completion flag too, unless a conversion is still running. In that case the write sets the completion flag and restarts the converter.

Top module: `adc_trig_ctrl`

## Requirements
- R1: With burst off and mode 000 held in the control register, no start pulse is issued, whatever the trigger lines do.
- R2: A control write with mode 001 and burst off raises `convStart` in the cycle after the write, for exactly one cycle.
- R3: Modes 010..111 select trigger line `trigIn[mode-2]`. Only an edge on that line starts a conversion. Edges on the other five lines have no effect.
- R4: With the polarity bit at 0, a rising edge starts a conversion. With the polarity bit at 1, a falling edge does. The opposite edge starts nothing.
- R5: A trigger edge that arrives while a conversion is in flight (between a start pulse and its done) is ignored.
- R6: The data word holds the result in bits 15:6, the channel in bits 26:24, the overrun flag in bit 30 and the done flag in bit 31. All other bits read 0, and the whole word is 0 after reset.
- R7: The done flag sets on a converter done. It clears on a data read, and on a control write made while no conversion is in flight. The captured result and channel stay in place.
- R8: A control write made while a conversion is in flight sets the done flag and issues a new start pulse in the next cycle.
- R9: With burst on, the mode field is ignored. A start is issued whenever no conversion is in flight, which includes the cycle after each done.
- R10: The overrun flag sets when a result is captured in burst mode while the done flag is still 1. A data read clears it.
- R11: If a converter done and a data read fall in the same cycle, the capture wins and the done flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlMode | input | 3 | Start mode written on `ctrlWr` |
| ctrlFall | input | 1 | Edge polarity written on `ctrlWr` (1 = falling) |
| dataRd | input | 1 | Data read strobe (clears flags) |
| dataOut | output | 32 | Data word |
| burstEn | input | 1 | Continuous conversion enable |
| trigIn | input | 6 | Asynchronous trigger lines |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convDone | input | 1 | Converter completion pulse |
| convResult | input | 10 | Converter result |
| convChan | input | 3 | Channel the result belongs to |

## Verification
The bench builds the block with its default parameters: six trigger lines, a two-stage synchronizer, a 10-bit result and a 3-bit channel. At this size every trigger mode can be swept against both polarities, with the five unselected lines toggled each time. All eight channel codes are captured with arithmetically generated result patterns. The flag interactions between done, read, control write and burst are each reached in a few dozen cycles.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int MODE_W    = 3;
  localparam int TRIG_BASE = 2;
  localparam logic [MODE_W-1:0] MODE_OFF = 3'd0;
  localparam logic [MODE_W-1:0] MODE_NOW = 3'd1;

  localparam int WORD_W  = 32;
  localparam int RES_LSB = 6;
  localparam int CH_LSB  = 24;
  localparam int OVR_BIT = 30;
  localparam int DONE_BIT = 31;

  typedef struct packed {
    logic capture;
    logic setDone;
    logic clrDone;
    logic setOvr;
    logic clrOvr;
  } flagStrobe_t;

endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int N_TRIG     = 6,
  parameter int SYNC_DEPTH = 2,
  parameter int RES_W      = 10,
  parameter int CH_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_TRIG-1:0] trigIn,
  input  flagStrobe_t       st,
  input  logic [RES_W-1:0]  convResult,
  input  logic [CH_W-1:0]   convChan,
  output logic [N_TRIG-1:0] trigRise,
  output logic [N_TRIG-1:0] trigFall,
  output logic              doneFlag,
  output logic [WORD_W-1:0] dataOut
);

  localparam int SHIFT_W = SYNC_DEPTH + 1;

  logic [RES_W-1:0] resQ;
  logic [CH_W-1:0]  chQ;
  logic             doneQ;
  logic             ovrQ;

  // Per-line synchronizer followed by one history stage for edge detection
  for (genvar g = 0; g < N_TRIG; g++) begin : gSync
    logic [SHIFT_W-1:0] shiftQ;
    always_ff @(posedge clk) begin
      if (!rstN) shiftQ <= '0;
      else       shiftQ <= {shiftQ[SHIFT_W-2:0], trigIn[g]};
    end
    assign trigRise[g] =  shiftQ[SYNC_DEPTH-1] & ~shiftQ[SYNC_DEPTH];
    assign trigFall[g] = ~shiftQ[SYNC_DEPTH-1] &  shiftQ[SYNC_DEPTH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ <= '0;
      chQ  <= '0;
    end else if (st.capture) begin
      resQ <= convResult;
      chQ  <= convChan;
    end
  end

  // Capture outranks every clear so no completion is lost
  always_ff @(posedge clk) begin
    if (!rstN)                        doneQ <= 1'b0;
    else if (st.capture || st.setDone) doneQ <= 1'b1;
    else if (st.clrDone)              doneQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          ovrQ <= 1'b0;
    else if (st.setOvr) ovrQ <= 1'b1;
    else if (st.clrOvr) ovrQ <= 1'b0;
  end

  assign doneFlag = doneQ;

  always_comb begin
    dataOut = '0;
    dataOut[RES_LSB +: RES_W] = resQ;
    dataOut[CH_LSB +: CH_W]   = chQ;
    dataOut[OVR_BIT]          = ovrQ;
    dataOut[DONE_BIT]         = doneQ;
  end

  a_r7_capture_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |=> dataOut[DONE_BIT]);

  a_r7_clear_drops_done: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrDone && !st.capture && !st.setDone) |=> !dataOut[DONE_BIT]);

  a_r10_ovr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!st.setOvr && !st.clrOvr) |=> $stable(dataOut[OVR_BIT]));

endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
  import adc_trig_pkg::*;
#(
  parameter int N_TRIG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [MODE_W-1:0] ctrlMode,
  input  logic              ctrlFall,
  input  logic              dataRd,
  input  logic              burstEn,
  input  logic              convDone,
  input  logic [N_TRIG-1:0] trigRise,
  input  logic [N_TRIG-1:0] trigFall,
  input  logic              doneFlag,
  output logic              convStart,
  output flagStrobe_t       st
);

  logic [MODE_W-1:0] modeQ;
  logic              fallQ;
  logic              inFlight;
  logic              trigHit;
  logic              startReq;
  logic              startQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
      fallQ <= 1'b0;
    end else if (ctrlWr) begin
      modeQ <= ctrlMode;
      fallQ <= ctrlFall;
    end
  end

  always_comb begin
    trigHit = 1'b0;
    for (int i = 0; i < N_TRIG; i++) begin
      if (modeQ == MODE_W'(TRIG_BASE + i))
        trigHit = fallQ ? trigFall[i] : trigRise[i];
    end
  end

  always_comb begin
    startReq = 1'b0;
    if (ctrlWr && inFlight)                       startReq = 1'b1;
    else if (ctrlWr && !burstEn && ctrlMode == MODE_NOW) startReq = 1'b1;
    else if (!ctrlWr && !inFlight && burstEn)     startReq = 1'b1;
    else if (!ctrlWr && !inFlight && !burstEn && trigHit) startReq = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      startQ <= startReq;
      if (startReq)      inFlight <= 1'b1;
      else if (convDone) inFlight <= 1'b0;
    end
  end

  assign convStart = startQ;

  always_comb begin
    st.capture = convDone;
    st.setDone = ctrlWr && inFlight;
    st.clrDone = ctrlWr || dataRd;
    st.setOvr  = convDone && burstEn && doneFlag;
    st.clrOvr  = dataRd;
  end

  a_r1_off_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!burstEn && !ctrlWr && modeQ == MODE_OFF && !inFlight) |=> !convStart);

  a_r2_now_starts: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlMode == MODE_NOW && !burstEn) |=> convStart);

  a_r5_busy_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && !ctrlWr) |=> !convStart);

  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && inFlight) |=> (convStart && doneFlag));

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int N_TRIG     = 6,
  parameter int SYNC_DEPTH = 2,
  parameter int RES_W      = 10,
  parameter int CH_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [MODE_W-1:0] ctrlMode,
  input  logic              ctrlFall,
  input  logic              dataRd,
  output logic [WORD_W-1:0] dataOut,
  input  logic              burstEn,
  input  logic [N_TRIG-1:0] trigIn,
  output logic              convStart,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  input  logic [CH_W-1:0]   convChan
);

  flagStrobe_t       st;
  logic [N_TRIG-1:0] trigRise;
  logic [N_TRIG-1:0] trigFall;
  logic              doneFlag;

  adc_trig_ctl #(.N_TRIG(N_TRIG)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlMode(ctrlMode),
    .ctrlFall(ctrlFall), .dataRd(dataRd), .burstEn(burstEn),
    .convDone(convDone), .trigRise(trigRise), .trigFall(trigFall),
    .doneFlag(doneFlag), .convStart(convStart), .st(st)
  );

  adc_trig_dp #(.N_TRIG(N_TRIG), .SYNC_DEPTH(SYNC_DEPTH), .RES_W(RES_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .st(st),
    .convResult(convResult), .convChan(convChan),
    .trigRise(trigRise), .trigFall(trigFall),
    .doneFlag(doneFlag), .dataOut(dataOut)
  );

  a_r10_ovr_from_burst: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOut[OVR_BIT]) |-> $past(burstEn && convDone && dataOut[DONE_BIT]));

  a_r11_capture_beats_read: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && dataRd) |=> dataOut[DONE_BIT]);

endmodule

// File: tb/test_adc_trig_ctrl.sv
module test_adc_trig_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [2:0]  ctrlMode = 3'd0;
  logic        ctrlFall = 1'b0;
  logic        dataRd = 1'b0;
  logic [31:0] dataOut;
  logic        burstEn = 1'b0;
  logic [5:0]  trigIn = 6'd0;
  logic        convStart;
  logic        convDone = 1'b0;
  logic [9:0]  convResult = 10'd0;
  logic [2:0]  convChan = 3'd0;

  int checks = 0;
  int fails  = 0;
  int startCnt = 0;

  always #4 clk = ~clk;

  adc_trig_ctrl i_adc_trig_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlMode(ctrlMode),
    .ctrlFall(ctrlFall), .dataRd(dataRd), .dataOut(dataOut),
    .burstEn(burstEn), .trigIn(trigIn), .convStart(convStart),
    .convDone(convDone), .convResult(convResult), .convChan(convChan)
  );

  always @(negedge clk) if (convStart) startCnt++;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic d, input logic o, input logic [2:0] c, input logic [9:0] r);
    return {d, o, 3'b000, c, 8'h00, r, 6'b000000};
  endfunction

  task automatic wrCtrl(input logic [2:0] m, input logic f);
    ctrlWr = 1'b1; ctrlMode = m; ctrlFall = f;
    tick();
    ctrlWr = 1'b0;
  endtask

  task automatic finishConv(input logic [9:0] r, input logic [2:0] c);
    convDone = 1'b1; convResult = r; convChan = c;
    tick();
    convDone = 1'b0;
  endtask

  task automatic readReg();
    dataRd = 1'b1;
    tick();
    dataRd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    logic [9:0] r;
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R6 reset word", dataOut, 32'h0);
    check("R1 no start after reset", startCnt, 0);

    // R1: mode off, triggers toggled
    wrCtrl(3'd0, 1'b0);
    trigIn = 6'h3F; tick(6);
    trigIn = 6'h00; tick(6);
    check("R1 mode off stays idle", startCnt, 0);

    // R2 / R6 / R7 sweep over channels
    for (int k = 0; k < 8; k++) begin
      r = 10'((k * 337 + 5) % 1024);
      c0 = startCnt;
      wrCtrl(3'd1, 1'b0);
      check("R2 start pulse issued", startCnt, c0 + 1);
      tick();
      check("R2 pulse one cycle", {31'd0, convStart}, 32'd0);
      finishConv(r, 3'(k));
      check("R6 R7 captured word", dataOut, word(1'b1, 1'b0, 3'(k), r));
      readReg();
      check("R7 read clears done", dataOut, word(1'b0, 1'b0, 3'(k), r));
    end

    // R7: control write clears done when idle
    wrCtrl(3'd1, 1'b0);
    finishConv(10'h3FF, 3'd5);
    check("R7 done set", dataOut, word(1'b1, 1'b0, 3'd5, 10'h3FF));
    wrCtrl(3'd0, 1'b0);
    check("R7 write clears done", dataOut, word(1'b0, 1'b0, 3'd5, 10'h3FF));

    // R3 / R4 sweep over trigger modes and polarities
    for (int m = 2; m < 8; m++) begin
      for (int f = 0; f < 2; f++) begin
        logic lvl;
        int sel;
        lvl = f[0];
        sel = m - 2;
        wrCtrl(3'd0, 1'b0);
        trigIn = {6{lvl}}; tick(5);
        wrCtrl(3'(m), f[0]);
        c0 = startCnt;
        trigIn = ~{6{lvl}};
        trigIn[sel] = lvl;
        tick(6);
        trigIn = {6{lvl}}; tick(6);
        check("R3 other lines ignored", startCnt, c0);
        trigIn[sel] = ~lvl; tick(6);
        check("R3 R4 selected edge starts", startCnt, c0 + 1);
        finishConv(10'(m * 100 + f), 3'(m));
        check("R6 trigger capture", dataOut, word(1'b1, 1'b0, 3'(m), 10'(m * 100 + f)));
        trigIn[sel] = lvl; tick(6);
        check("R4 opposite edge ignored", startCnt, c0 + 1);
        readReg();
      end
    end

    // R5: edge during conversion ignored
    wrCtrl(3'd0, 1'b0);
    trigIn = 6'h00; tick(5);
    wrCtrl(3'd2, 1'b0);
    c0 = startCnt;
    trigIn[0] = 1'b1; tick(6);
    check("R5 first edge starts", startCnt, c0 + 1);
    trigIn[0] = 1'b0; tick(4);
    trigIn[0] = 1'b1; tick(6);
    check("R5 busy edge ignored", startCnt, c0 + 1);
    finishConv(10'h155, 3'd1);
    trigIn = 6'h00; tick(5);
    readReg();

    // R8: write during conversion
    wrCtrl(3'd1, 1'b0);
    c0 = startCnt;
    tick(2);
    wrCtrl(3'd0, 1'b0);
    check("R8 restart pulse", startCnt, c0 + 1);
    check("R8 done forced", {31'd0, dataOut[31]}, 32'd1);
    finishConv(10'h0AA, 3'd2);
    readReg();
    check("R8 flags cleared", dataOut, word(1'b0, 1'b0, 3'd2, 10'h0AA));

    // R11: capture and read in the same cycle
    wrCtrl(3'd1, 1'b0);
    convDone = 1'b1; convResult = 10'h123; convChan = 3'd6; dataRd = 1'b1;
    tick();
    convDone = 1'b0; dataRd = 1'b0;
    check("R11 capture wins", dataOut, word(1'b1, 1'b0, 3'd6, 10'h123));
    readReg();

    // R9 / R10: burst mode with mode field off
    wrCtrl(3'd0, 1'b0);
    c0 = startCnt;
    burstEn = 1'b1; tick(3);
    check("R9 burst starts with mode off", startCnt, c0 + 1);
    finishConv(10'h011, 3'd3);
    check("R10 no overrun on first", dataOut, word(1'b1, 1'b0, 3'd3, 10'h011));
    tick(3);
    check("R9 auto restart", startCnt, c0 + 2);
    finishConv(10'h022, 3'd4);
    check("R10 overrun set", dataOut, word(1'b1, 1'b1, 3'd4, 10'h022));
    readReg();
    check("R10 read clears overrun", dataOut, word(1'b0, 1'b0, 3'd4, 10'h022));
    tick(3);
    check("R9 restart after second", startCnt, c0 + 3);
    burstEn = 1'b0;
    finishConv(10'h033, 3'd0);
    check("R10 no overrun after read", dataOut, word(1'b1, 1'b0, 3'd0, 10'h033));
    tick(4);
    check("R9 no start after burst off", startCnt, c0 + 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule